// File: doc/BRIEF.md
# Video Packet Framer

This block sits between a pixel FIFO and a downstream video scaler. It waits for a frame-start pulse, then sends one video packet onto a valid/ready streaming interface. The packet opens with a header beat whose data is all zeros and which carries start-of-packet. This zero value tells the receiver that the packet holds video. After the header come exactly `FRAME_W * FRAME_H` pixel beats, each one popped from the FIFO. End-of-packet marks the last pixel.

The downstream ready signal has a latency of one cycle. The block may present a beat only in a cycle that follows a cycle in which ready was high. FIFO reads follow the same rule, so every pop becomes exactly one pixel beat in the same cycle. An internal pixel counter ends the packet. The frame-end pulse only has to pair with an accepted frame start.

When a frame-start pulse arrives while a packet is still open, the block ignores it. An unmatched frame-end pulse is also a sequencing fault. Either fault sets a flag that stays set until reset.

Top module: `vid_pkt_framer`

## Requirements
- R1: After reset, `src_valid`, `fifo_rd` and `seq_err` are all 0, and no beat is sent until a frame-start pulse is accepted.
- R2: The first beat after an accepted frame start is the header: `src_sop`=1, `src_eop`=0, and `src_data` all zeros. It is sent in the first cycle, counted from the cycle after the pulse, that follows a cycle with `src_ready` high.
- R3: `src_valid` is 1 only in a cycle whose previous cycle had `src_ready` high.
- R4: Each pixel beat carries the FIFO word presented in that cycle, and `fifo_rd` is 1 in exactly those cycles. Pixels leave in FIFO order, and none is lost or duplicated.
- R5: A packet holds exactly `FRAME_W*FRAME_H` pixel beats after the header. `src_eop` is 1 on the last pixel beat only, and `src_sop` is 1 on the header only.
- R6: A frame-start pulse that arrives while a packet is open has no effect on the packet, and it sets `seq_err`. `seq_err` stays 1 until reset.
- R7: A frame-end pulse with no accepted frame start still awaiting its end sets `seq_err`. A frame-end pulse never changes the beats.
- R8: After the end-of-packet beat, no beat is sent and the FIFO is not read until the next frame-start pulse.
- R9: While `fifo_empty` is 1, neither `fifo_rd` nor a pixel beat occurs; the packet resumes when data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that opens a packet |
| frame_end | input | 1 | One-cycle pulse that closes the frame pairing |
| fifo_rdata | input | DATA_W | Show-ahead FIFO head word |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_rd | output | 1 | Pop the FIFO head word |
| src_ready | input | 1 | Downstream ready, latency one |
| src_valid | output | 1 | Beat valid |
| src_data | output | DATA_W | Beat data (zero on header) |
| src_sop | output | 1 | Start of packet (header beat) |
| src_eop | output | 1 | End of packet (last pixel) |
| seq_err | output | 1 | Sticky sequencing-fault flag |

## Verification
The bench drives ready in three ways: held high, alternating, and high two cycles in three. Under every pattern it checks that no beat appears after a low-ready cycle. A design that used the current ready would send beats the scaler then drops. Starving the FIFO in the middle of a frame shows whether the block reads or sends while empty, which would duplicate or invent pixels. Holding ready low after a start shows whether the header waits for ready. A second start in the middle of a packet, and a lone frame end, must each raise the sticky flag while the packet keeps its exact length and single start marker. A design that restarted would emit two headers. After end-of-packet, spare FIFO words must stay unread, or the next frame would shift.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PIX  = 2'd2
  } vpf_state_e;

  // Pixel beats in one packet.
  function automatic int unsigned pix_total(input int unsigned w, input int unsigned h);
    return w * h;
  endfunction

  // Counter width able to hold indices 0 .. total-1.
  function automatic int unsigned cnt_width(input int unsigned total);
    return (total > 1) ? $clog2(total) : 1;
  endfunction

  // True when the given pixel index is the final one of the packet.
  function automatic logic at_terminal(input int unsigned idx, input int unsigned total);
    return idx == (total - 1);
  endfunction

endpackage

// File: rtl/vpf_ready_tracker.sv
module vpf_ready_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  output logic ready_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready;
  end

endmodule

// File: rtl/vpf_pixel_counter.sv
module vpf_pixel_counter
  import vpf_pkg::*;
#(
  parameter int unsigned TOTAL = 16,
  localparam int unsigned CW   = cnt_width(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          last
);

  assign last = at_terminal(int'(cnt), TOTAL);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= last ? '0 : cnt + 1'b1;
  end

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < TOTAL);

endmodule

// File: rtl/vpf_seq_ctrl.sv
module vpf_seq_ctrl
  import vpf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       frame_end,
  input  logic       ready_q,
  input  logic       fifo_empty,
  input  logic       last_pix,
  output vpf_state_e state_q,
  output logic       hdr_fire,
  output logic       pix_fire,
  output logic       err_q
);

  vpf_state_e state_d;
  logic       owed_q;
  logic       start_accept;
  logic       start_reject;
  logic       end_orphan;

  assign start_accept = frame_start && (state_q == ST_IDLE);
  assign start_reject = frame_start && (state_q != ST_IDLE);
  assign end_orphan   = frame_end && !owed_q;

  assign hdr_fire = (state_q == ST_HDR) && ready_q;
  assign pix_fire = (state_q == ST_PIX) && ready_q && !fifo_empty;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_accept)         state_d = ST_HDR;
      ST_HDR:  if (hdr_fire)             state_d = ST_PIX;
      ST_PIX:  if (pix_fire && last_pix) state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owed_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_accept)   owed_q <= 1'b1;
      else if (frame_end) owed_q <= 1'b0;
      if (start_reject || end_orphan) err_q <= 1'b1;
    end
  end

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  a_r6_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> err_q);

  a_r7_orphan_flags: assert property (@(posedge clk) disable iff (!rst_n)
    end_orphan |=> err_q);

  a_r2_hdr_opens_pixels: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |=> (state_q == ST_PIX));

endmodule

// File: rtl/vid_pkt_framer.sv
module vid_pkt_framer
  import vpf_pkg::*;
#(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned FRAME_W = 720,
  parameter int unsigned FRAME_H = 288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  input  logic              src_ready,
  output logic              src_valid,
  output logic [DATA_W-1:0] src_data,
  output logic              src_sop,
  output logic              src_eop,
  output logic              seq_err
);

  localparam int unsigned TOTAL = pix_total(FRAME_W, FRAME_H);
  localparam int unsigned CW    = cnt_width(TOTAL);

  logic          ready_q;
  logic          hdr_fire;
  logic          pix_fire;
  logic          last_pix;
  logic [CW-1:0] pix_idx;
  vpf_state_e    state_q;

  vpf_ready_tracker u_ready (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (src_ready),
    .ready_q (ready_q)
  );

  vpf_pixel_counter #(.TOTAL(TOTAL)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (hdr_fire),
    .step  (pix_fire),
    .cnt   (pix_idx),
    .last  (last_pix)
  );

  vpf_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .ready_q     (ready_q),
    .fifo_empty  (fifo_empty),
    .last_pix    (last_pix),
    .state_q     (state_q),
    .hdr_fire    (hdr_fire),
    .pix_fire    (pix_fire),
    .err_q       (seq_err)
  );

  assign fifo_rd   = pix_fire;
  assign src_valid = hdr_fire || pix_fire;
  assign src_sop   = hdr_fire;
  assign src_eop   = pix_fire && last_pix;
  assign src_data  = pix_fire ? fifo_rdata : '0;

  a_r3_valid_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> $past(src_ready));

  a_r9_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  a_r2_sop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    src_sop |-> (src_valid && (src_data == '0) && !src_eop));

  a_r5_eop_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    src_eop |-> (src_valid && fifo_rd && !src_sop));

  a_r8_quiet_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    src_eop |=> !src_valid);

endmodule

// File: tb/vid_pkt_framer_bench.sv
module vid_pkt_framer_bench;

  localparam int DW    = 24;
  localparam int FW    = 4;
  localparam int FH    = 3;
  localparam int TOTAL = FW * FH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic          frame_end = 1'b0;
  logic [DW-1:0] fifo_rdata;
  logic          fifo_empty;
  logic          fifo_rd;
  logic          src_ready = 1'b0;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          src_sop;
  logic          src_eop;
  logic          seq_err;

  always #4 clk = ~clk;

  vid_pkt_framer #(.DATA_W(DW), .FRAME_W(FW), .FRAME_H(FH)) u_vid_pkt_framer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .src_ready(src_ready), .src_valid(src_valid), .src_data(src_data),
    .src_sop(src_sop), .src_eop(src_eop), .seq_err(seq_err)
  );

  // Show-ahead FIFO model
  logic [DW-1:0] fmem [0:63];
  int wr_ptr = 0;
  int rd_ptr = 0;
  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_rdata = fmem[rd_ptr % 64];
  always @(posedge clk) if (fifo_rd) rd_ptr <= rd_ptr + 1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Beat capture at the falling edge
  logic [DW-1:0] cap_data [0:63];
  logic          cap_sop  [0:63];
  logic          cap_eop  [0:63];
  int  ncap = 0;
  int  viol_ready = 0;
  int  viol_empty = 0;
  logic prev_ready = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (src_valid && !prev_ready) viol_ready++;
      if (fifo_rd && fifo_empty) viol_empty++;
      if (src_valid) begin
        if (ncap < 64) begin
          cap_data[ncap] = src_data;
          cap_sop[ncap]  = src_sop;
          cap_eop[ncap]  = src_eop;
        end
        ncap++;
      end
    end
    prev_ready = src_ready;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R5 watchdog actual %0d expected below %0d", cycles, 100000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pix(input int f, input int i);
    return DW'((f << 16) + i + 1);
  endfunction

  task automatic push(input logic [DW-1:0] v);
    fmem[wr_ptr % 64] = v;
    wr_ptr++;
  endtask

  task automatic push_frame(input int f, input int from, input int upto);
    for (int i = from; i < upto; i++) push(pix(f, i));
  endtask

  // mode 0: hold, 1: alternate, 2: two of three high
  task automatic run(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      if (mode == 1) src_ready = c[0];
      else if (mode == 2) src_ready = (c % 3) != 0;
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(posedge clk); #1 frame_end = 1'b1;
    @(posedge clk); #1 frame_end = 1'b0;
  endtask

  task automatic clear_cap();
    ncap = 0; viol_ready = 0; viol_empty = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; src_ready = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
    wr_ptr = rd_ptr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    clear_cap();
  endtask

  task automatic verify_frame(input int f, input string req);
    int bad_data = 0;
    int bad_mark = 0;
    chk(ncap == TOTAL + 1, req, ncap, TOTAL + 1);
    chk(cap_sop[0] && !cap_eop[0] && cap_data[0] == '0, "R2", cap_data[0], 0);
    for (int i = 0; i < TOTAL && i + 1 < 64; i++) begin
      if (cap_data[i+1] != pix(f, i)) bad_data++;
      if (cap_sop[i+1] || (cap_eop[i+1] != (i == TOTAL - 1))) bad_mark++;
    end
    chk(bad_data == 0, "R4", bad_data, 0);
    chk(bad_mark == 0, "R5", bad_mark, 0);
    chk(viol_ready == 0, "R3", viol_ready, 0);
    chk(viol_empty == 0, "R9", viol_empty, 0);
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    chk(!src_valid && !fifo_rd, "R1", {src_valid, fifo_rd}, 0);
    chk(!seq_err, "R1", seq_err, 0);
    src_ready = 1'b1;
    push_frame(9, 0, 2);
    run(6, 0);
    chk(ncap == 0, "R1", ncap, 0);
    wr_ptr = rd_ptr;
  endtask

  task automatic t_basic();
    clear_cap();
    src_ready = 1'b1;
    push_frame(1, 0, TOTAL);
    pulse_start();
    run(TOTAL + 6, 0);
    pulse_end();
    verify_frame(1, "R5");
    chk(!seq_err, "R7", seq_err, 0);
  endtask

  task automatic t_ready_pattern(input int f, input int mode);
    clear_cap();
    push_frame(f, 0, TOTAL);
    pulse_start();
    run(4 * TOTAL + 10, mode);
    pulse_end();
    src_ready = 1'b1;
    verify_frame(f, "R3");
  endtask

  task automatic t_stall();
    clear_cap();
    src_ready = 1'b1;
    push_frame(4, 0, 5);
    pulse_start();
    run(20, 0);
    chk(ncap == 6, "R9", ncap, 6);
    chk(viol_empty == 0 && !fifo_rd, "R9", viol_empty, 0);
    push_frame(4, 5, TOTAL);
    run(TOTAL + 6, 0);
    pulse_end();
    verify_frame(4, "R9");
  endtask

  task automatic t_ready_late();
    clear_cap();
    src_ready = 1'b0;
    push_frame(5, 0, TOTAL);
    pulse_start();
    run(5, 0);
    chk(ncap == 0, "R2", ncap, 0);
    src_ready = 1'b1;
    run(TOTAL + 6, 0);
    pulse_end();
    verify_frame(5, "R2");
  endtask

  task automatic t_after_eop();
    int rp;
    clear_cap();
    rp = rd_ptr;
    push_frame(6, 0, 4);
    run(12, 0);
    chk(ncap == 0, "R8", ncap, 0);
    chk(rd_ptr == rp, "R8", rd_ptr, rp);
    do_reset();
  endtask

  task automatic t_mid_start();
    clear_cap();
    src_ready = 1'b1;
    push_frame(7, 0, 3);
    pulse_start();
    run(6, 0);
    pulse_start();
    #1;
    chk(seq_err, "R6", seq_err, 1);
    push_frame(7, 3, TOTAL);
    run(TOTAL + 10, 0);
    pulse_end();
    verify_frame(7, "R6");
    push_frame(8, 0, 2);
    run(8, 0);
    chk(ncap == TOTAL + 1, "R6", ncap, TOTAL + 1);
    chk(seq_err, "R6", seq_err, 1);
  endtask

  task automatic t_orphan_end();
    do_reset();
    chk(!seq_err, "R7", seq_err, 0);
    src_ready = 1'b1;
    pulse_end();
    run(2, 0);
    chk(seq_err, "R7", seq_err, 1);
    chk(ncap == 0, "R7", ncap, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_ready_pattern(2, 1);
    t_ready_pattern(3, 2);
    t_stall();
    t_ready_late();
    t_after_eop();
    t_mid_start();
    t_orphan_end();
    summary();
    $finish;
  end

endmodule